// File: doc/BRIEF.md
# Message-Buffered SPI Master Engine

This block is an SPI master that runs one complete message per start command. Software loads the bytes to send into a transmit buffer and writes a message control word. That word gives the byte count and one of three transfer types: full duplex, write only or read only. Software then issues a start command. The command names the target device and, if wanted, a count of leading "prepend" bytes. The engine asserts one chip select and shifts every byte of the message, most significant bit first. It stores received bytes in a separate receive buffer, releases the chip select after the last byte and flags command-done.

A prepend count lets a single chip-select assertion carry a short write, such as a command or an address, followed by a read. The prepend bytes are sent from the start of the transmit buffer and nothing is captured while they go out. The bytes that follow land in the receive buffer from offset zero. Interrupt status, interrupt mask, a fill byte for read-only phases and a live status word are reached through the same register port. The serial clock comes from a fixed divider parameter. Each half period lasts `HALF_CYC` system clocks.

Top module: `msg_spi_master`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, the interrupt is low, interrupt status reads 0 and the status word reads 0x0002.
- R2: Address map. The top two address bits select a region: 0 is the transmit buffer (write only), 1 is the receive buffer (read only, data in bits 7:0) and 2 is control. A control address must have zero offset bits above bit 2. Control sub-addresses are: 0 message control, 1 command, 2 interrupt status, 3 interrupt mask, 4 status (read only), 5 fill byte. In message control the byte count sits in bits 13:0 and the type in bits 15:14. The types are 0 full duplex, 1 write only, 2 read only, and 3, which behaves as write only. In a command, bits 3:0 select the operation: 0 no-op, 1 soft reset, 2 hard reset, 3 start. The device index is in bits 6:4 and the prepend count in bits 11:8. An accepted start makes the engine busy on the next cycle.
- R3: Each byte is 8 bits, sent MSB first in SPI mode 0: the clock idles low and the slave samples on the rising edge. Each clock phase lasts `HALF_CYC` system clocks, and the message carries exactly the number of bytes in the byte count.
- R4: In full duplex, byte i is sent from transmit-buffer entry i and the byte received with it is stored in receive entry i.
- R5: In write only mode, transmit entries are sent and the receive buffer keeps its previous contents.
- R6: In read only mode, the fill-byte register value is sent for every byte and the received bytes are stored from receive entry 0.
- R7: With prepend count P, bytes 0 to P-1 are sent from the transmit buffer and none of them is captured. From byte P onward the type rules apply, and a captured byte i goes to receive entry i-P.
- R8: While a message runs, exactly the chip select named by the device index is low. No other chip select is ever low, and no chip select is low while the engine is idle.
- R9: When the last byte completes, the chip select goes high and interrupt status bit 0 (command done) is set. A byte count of 0 completes with no chip select and no clock.
- R10: The interrupt output is high only when a set status bit has its mask bit set. Status bits are set even while masked. Writing a one to a status bit clears it.
- R11: A start while busy sets interrupt status bit 3 and does not disturb the running message.
- R12: A start with a byte count larger than the buffer sets interrupt status bit 2 and runs no transfer.
- R13: Status bit 1 is high when the last message captured no byte, bit 2 is high while a command runs, and bit 3 is high while a byte is being shifted. Bit 3 implies bit 2.
- R14: A soft reset aborts a running message at once: chip selects go high, busy clears and command done is not set. A hard reset also returns message control, mask and interrupt status to 0 and the fill byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register or buffer write strobe |
| reg_addr | input | ADDR_W | Register or buffer address, region in the top two bits |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle: that at most one chip select is ever low, that a chip select is only low while a command is busy, that the serial clock rests low whenever no byte is shifting, and that a masked-off interrupt never fires. They also check the flag effects of command done, start-while-busy and accepted starts. Only the bench scenarios can show that the right bytes travel: which transmit entry or fill byte goes out on each byte, where each received byte lands for every type and prepend count, and that untouched receive entries keep their contents. The bench also shows the byte count per message, the clock phase length, soft-reset abort and the register values after a hard reset.

// File: rtl/msg_spi_pkg.sv
package msg_spi_pkg;

  typedef enum logic [1:0] {
    XF_FULL  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2,
    XF_RSVD  = 2'd3
  } xfer_e;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_SOFT = 4'd1;
  localparam logic [3:0] OP_HARD = 4'd2;
  localparam logic [3:0] OP_GO   = 4'd3;

  localparam logic [1:0] RG_TXBUF = 2'd0;
  localparam logic [1:0] RG_RXBUF = 2'd1;
  localparam logic [1:0] RG_CTRL  = 2'd2;

  localparam logic [2:0] SA_MSGCTL = 3'd0;
  localparam logic [2:0] SA_CMD    = 3'd1;
  localparam logic [2:0] SA_IST    = 3'd2;
  localparam logic [2:0] SA_IMASK  = 3'd3;
  localparam logic [2:0] SA_STAT   = 3'd4;
  localparam logic [2:0] SA_FILL   = 3'd5;

  localparam int IB_DONE  = 0;
  localparam int IB_RXOVF = 1;
  localparam int IB_TXUND = 2;
  localparam int IB_TXOVF = 3;
  localparam int IB_RXUND = 4;

  // byte idx of a message is taken from the transmit buffer (else the fill byte)
  function automatic logic sends_buffer(xfer_e t, logic [15:0] idx, logic [3:0] pre);
    return (idx < {12'd0, pre}) || (t != XF_READ);
  endfunction

  // byte idx of a message is written into the receive buffer
  function automatic logic stores_rx(xfer_e t, logic [15:0] idx, logic [3:0] pre);
    return (idx >= {12'd0, pre}) && ((t == XF_FULL) || (t == XF_READ));
  endfunction

endpackage

// File: rtl/msg_spi_bytebuf.sv
module msg_spi_bytebuf #(
  parameter int DEPTH = 542,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_idx) < DEPTH)) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    if (32'(rd_idx) < DEPTH) rd_data = mem[rd_idx];
    else                     rd_data = 8'd0;
  end
endmodule

// File: rtl/msg_spi_shifter.sv
module msg_spi_shifter #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             sclk_q, busy_q, done_q;
  logic             half_tick;

  assign half_tick = busy_q && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        tx_q   <= tx_byte;
        busy_q <= 1'b1;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (half_tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/msg_spi_seq.sv
module msg_spi_seq
  import msg_spi_pkg::*;
#(
  parameter int BUF_BYTES = 542,
  parameter int IDX_W     = $clog2(BUF_BYTES),
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  xfer_e            go_type,
  input  logic [CNT_W-1:0] go_count,
  input  logic [3:0]       go_pre,
  output logic [IDX_W-1:0] tx_idx,
  input  logic [7:0]       tx_data,
  input  logic [7:0]       fill,
  output logic             sh_start,
  output logic [7:0]       sh_byte,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_wdata,
  output logic             cs_act,
  output logic             busy,
  output logic             done_evt
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_FIN} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] idx_q, cnt_q;
  logic [3:0]       pre_q;
  xfer_e            typ_q;
  logic             last_byte;

  assign last_byte = (idx_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      pre_q <= '0;
      typ_q <= XF_FULL;
    end else begin
      unique case (st_q)
        S_IDLE: if (go) begin
          typ_q <= go_type;
          cnt_q <= go_count;
          pre_q <= go_pre;
          idx_q <= '0;
          st_q  <= (go_count == '0) ? S_FIN : S_LOAD;
        end
        S_LOAD: st_q <= S_WAIT;
        S_WAIT: if (sh_done) begin
          if (last_byte) st_q <= S_FIN;
          else begin
            idx_q <= idx_q + CNT_W'(1);
            st_q  <= S_LOAD;
          end
        end
        S_FIN:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tx_idx   = idx_q[IDX_W-1:0];
  assign sh_start = (st_q == S_LOAD);
  assign sh_byte  = sends_buffer(typ_q, 16'(idx_q), pre_q) ? tx_data : fill;
  assign rx_we    = (st_q == S_WAIT) && sh_done && stores_rx(typ_q, 16'(idx_q), pre_q);
  assign rx_idx   = idx_q[IDX_W-1:0] - IDX_W'(pre_q);
  assign rx_wdata = sh_rx;
  assign cs_act   = (st_q == S_LOAD) || (st_q == S_WAIT);
  assign busy     = (st_q != S_IDLE);
  assign done_evt = (st_q == S_FIN);
endmodule

// File: rtl/msg_spi_master.sv
module msg_spi_master
  import msg_spi_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int BUF_BYTES = 542,
  parameter int HALF_CYC  = 4,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              irq
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam logic [7:0] FILL_RST = 8'hFF;

  // register state
  logic [15:0] msg_ctl;
  logic [4:0]  int_st, int_st_nx, int_mask;
  logic [7:0]  fill;
  logic [2:0]  dev_q;
  logic        rx_empty;

  // decoded events, named for the checker
  logic [1:0]  region;
  logic [2:0]  sub;
  logic        ctrl_hit, cmd_wr, start_req, start_acc, start_rej_busy, start_rej_len;
  logic        soft_evt, hard_evt, abort;
  logic        cmd_busy, ser_busy, done_evt, cs_act;

  // datapath between submodules
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic [7:0]       tx_data, rx_wdata, rx_rdata, sh_byte, sh_rx;
  logic             sh_start, sh_done, rx_we, tx_we;

  assign region   = reg_addr[ADDR_W-1:ADDR_W-2];
  assign sub      = reg_addr[2:0];
  assign ctrl_hit = (region == RG_CTRL) && (reg_addr[ADDR_W-3:3] == '0);
  assign cmd_wr   = reg_we && ctrl_hit && (sub == SA_CMD);
  assign tx_we    = reg_we && (region == RG_TXBUF);

  assign start_req      = cmd_wr && (reg_wdata[3:0] == OP_GO);
  assign start_rej_busy = start_req && cmd_busy;
  assign start_rej_len  = start_req && !cmd_busy && (32'(msg_ctl[13:0]) > BUF_BYTES);
  assign start_acc      = start_req && !cmd_busy && !(32'(msg_ctl[13:0]) > BUF_BYTES);
  assign soft_evt       = cmd_wr && (reg_wdata[3:0] == OP_SOFT);
  assign hard_evt       = cmd_wr && (reg_wdata[3:0] == OP_HARD);
  assign abort          = soft_evt || hard_evt;

  msg_spi_bytebuf #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W)) u_txbuf (
    .clk     (clk),
    .wr_en   (tx_we),
    .wr_idx  (reg_addr[IDX_W-1:0]),
    .wr_data (reg_wdata[7:0]),
    .rd_idx  (tx_idx),
    .rd_data (tx_data)
  );

  msg_spi_bytebuf #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W)) u_rxbuf (
    .clk     (clk),
    .wr_en   (rx_we),
    .wr_idx  (rx_idx),
    .wr_data (rx_wdata),
    .rd_idx  (reg_addr[IDX_W-1:0]),
    .rd_data (rx_rdata)
  );

  msg_spi_seq #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .go       (start_acc),
    .go_type  (xfer_e'(msg_ctl[15:14])),
    .go_count (msg_ctl[CNT_W-1:0]),
    .go_pre   (reg_wdata[11:8]),
    .tx_idx   (tx_idx),
    .tx_data  (tx_data),
    .fill     (fill),
    .sh_start (sh_start),
    .sh_byte  (sh_byte),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .rx_we    (rx_we),
    .rx_idx   (rx_idx),
    .rx_wdata (rx_wdata),
    .cs_act   (cs_act),
    .busy     (cmd_busy),
    .done_evt (done_evt)
  );

  msg_spi_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .start   (sh_start),
    .tx_byte (sh_byte),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (ser_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  // chip-select decode, one output per device index
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = !(cs_act && (32'(dev_q) == g));
  end

  always_comb begin
    int_st_nx = int_st;
    if (reg_we && ctrl_hit && (sub == SA_IST)) int_st_nx = int_st_nx & ~reg_wdata[4:0];
    if (done_evt)       int_st_nx[IB_DONE]  = 1'b1;
    if (start_rej_len)  int_st_nx[IB_TXUND] = 1'b1;
    if (start_rej_busy) int_st_nx[IB_TXOVF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hard_evt) begin
      msg_ctl  <= '0;
      int_st   <= '0;
      int_mask <= '0;
      fill     <= FILL_RST;
      dev_q    <= '0;
      rx_empty <= 1'b1;
    end else begin
      int_st <= int_st_nx;
      if (reg_we && ctrl_hit && (sub == SA_MSGCTL)) msg_ctl  <= reg_wdata;
      if (reg_we && ctrl_hit && (sub == SA_IMASK))  int_mask <= reg_wdata[4:0];
      if (reg_we && ctrl_hit && (sub == SA_FILL))   fill     <= reg_wdata[7:0];
      if (start_acc) begin
        dev_q    <= reg_wdata[6:4];
        rx_empty <= 1'b1;
      end else if (rx_we) begin
        rx_empty <= 1'b0;
      end
    end
  end

  assign irq = |(int_st & int_mask);

  always_comb begin
    reg_rdata = '0;
    if (region == RG_RXBUF) begin
      reg_rdata = {8'd0, rx_rdata};
    end else if (ctrl_hit) begin
      unique case (sub)
        SA_MSGCTL: reg_rdata = msg_ctl;
        SA_IST:    reg_rdata = {11'd0, int_st};
        SA_IMASK:  reg_rdata = {11'd0, int_mask};
        SA_STAT:   reg_rdata = {12'd0, ser_busy, cmd_busy, rx_empty, 1'b0};
        SA_FILL:   reg_rdata = {8'd0, fill};
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/msg_spi_chk.sv
module msg_spi_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic              irq,
  input logic [4:0]        int_mask,
  input logic [4:0]        int_st,
  input logic              cmd_busy,
  input logic              ser_busy,
  input logic              done_evt,
  input logic              hard_evt,
  input logic              start_acc,
  input logic              start_rej_busy
);
  AST_CS_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R8
  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (~cs_n != '0) |-> cmd_busy); // R8
  AST_DONE_CS_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) done_evt |-> (&cs_n)); // R9
  AST_DONE_FLAG:     assert property (@(posedge clk) disable iff (!rst_n) (done_evt && !hard_evt) |=> int_st[0]); // R9
  AST_MASKED_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (int_mask == 5'd0) |-> !irq); // R10
  AST_SCLK_REST:     assert property (@(posedge clk) disable iff (!rst_n) !ser_busy |-> !sclk); // R3
  AST_OVF_FLAG:      assert property (@(posedge clk) disable iff (!rst_n) start_rej_busy |=> int_st[3]); // R11
  AST_GO_BUSY:       assert property (@(posedge clk) disable iff (!rst_n) start_acc |=> cmd_busy); // R2
  AST_SER_IN_CMD:    assert property (@(posedge clk) disable iff (!rst_n) ser_busy |-> cmd_busy); // R13
endmodule

bind msg_spi_master msg_spi_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs_n           (spi_cs_n),
  .sclk           (spi_sclk),
  .irq            (irq),
  .int_mask       (int_mask),
  .int_st         (int_st),
  .cmd_busy       (cmd_busy),
  .ser_busy       (ser_busy),
  .done_evt       (done_evt),
  .hard_evt       (hard_evt),
  .start_acc      (start_acc),
  .start_rej_busy (start_rej_busy)
);

// File: tb/tb_msg_spi_master.sv
module tb_msg_spi_master;
  localparam int BUF   = 24;
  localparam int HALF  = 2;
  localparam int NCS   = 8;
  localparam int IDX_W = $clog2(BUF);
  localparam int AW    = IDX_W + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;
  logic            spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0]  spi_cs_n;
  logic            irq;

  int checks = 0, failures = 0, msgno = 0, cyc_n = 0;
  int sbit, sbyte, cs_err, rise_c, fall_c;
  logic slv_clr = 1'b0;
  logic [NCS-1:0] exp_cs = '1;
  logic [7:0] ssh;
  logic [7:0] slog [64];
  logic [7:0] mdl [BUF];
  logic       known [BUF];
  logic [7:0] cur_pat;

  msg_spi_master #(.NUM_CS(NCS), .BUF_BYTES(BUF), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
  );

  always #2.5ns clk = ~clk;

  function automatic logic [7:0] txpat(int m, int i);
    return 8'((i * 13) + (m * 11) + 1);
  endfunction
  function automatic logic [7:0] slvpat(int m, int i);
    return 8'(((i * 29) + (m * 7) + 3) ^ 8'h5a);
  endfunction
  function automatic logic [AW-1:0] ca(int s);
    return AW'(2 << (AW - 2)) | AW'(s);
  endfunction
  function automatic logic [AW-1:0] rxa(int i);
    return AW'(1 << (AW - 2)) | AW'(i);
  endfunction

  // slave model: mode 0, MSB first
  assign cur_pat  = slvpat(msgno, sbyte);
  assign spi_miso = cur_pat[3'(7 - sbit)];

  always @(posedge spi_sclk or posedge slv_clr) begin
    if (slv_clr) begin
      sbit = 0; sbyte = 0; cs_err = 0;
    end else begin
      rise_c = cyc_n;
      if (spi_cs_n !== exp_cs) cs_err = cs_err + 1;
      ssh = {ssh[6:0], spi_mosi};
      if (sbit == 7) begin
        if (sbyte < 64) slog[sbyte] = ssh;
        sbyte = sbyte + 1;
        sbit = 0;
      end else sbit = sbit + 1;
    end
  end
  always @(negedge spi_sclk) fall_c = cyc_n;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(negedge clk) begin
    cyc_n = cyc_n + 1;
    if (cyc_n == 150000) begin
      failures = failures + 1;
      $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc_n);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1ns d = reg_rdata;
  endtask

  task automatic clr_slave();
    @(negedge clk); slv_clr = 1'b1;
    @(negedge clk); slv_clr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    bit idle = 0;
    for (int k = 0; k < 4000 && !idle; k++) begin
      rd(ca(4), v);
      if (!v[2]) idle = 1;
    end
    chk(idle, "R9", "message completion", idle, 1);
  endtask

  task automatic run_msg(input int typ, input int cnt, input int dev, input int pre, input bit dbl);
    string rq;
    logic [15:0] v;
    logic [7:0] fillv, e;
    bit cap = 0;
    rq = (pre > 0) ? "R7" : (typ == 0) ? "R4" : (typ == 1) ? "R5" : (typ == 2) ? "R6" : "R2";
    for (int i = 0; i < cnt; i++) wr(AW'(i), {8'd0, txpat(msgno, i)});
    fillv = 8'((msgno * 3) + 8'h41);
    wr(ca(5), {8'd0, fillv});
    wr(ca(0), {2'(typ), 14'(cnt)});
    exp_cs = ~(NCS'(1) << dev);
    clr_slave();
    wr(ca(1), 16'((pre << 8) | (dev << 4) | 3));
    if (dbl) begin
      wr(ca(1), 16'((((dev + 1) % 8) << 4) | 3));
      rd(ca(2), v);
      chk(v[3] == 1'b1, "R11", "start-while-busy flag", v, 16'h8);
    end
    wait_idle();
    rd(ca(2), v);
    chk(v[0] == 1'b1, "R9", "command done flag", v, 1);
    wr(ca(2), 16'h001f);
    chk(sbyte == cnt, "R3", "bytes on the wire", sbyte, cnt);
    for (int i = 0; i < cnt; i++) begin
      e = ((i < pre) || (typ != 2)) ? txpat(msgno, i) : fillv;
      chk(slog[i] == e, rq, $sformatf("mosi byte %0d", i), slog[i], e);
    end
    chk(cs_err == 0, "R8", "wrong chip select during clocks", cs_err, 0);
    chk(spi_cs_n == '1, "R8", "chip selects after message", spi_cs_n, '1);
    if ((typ == 0) || (typ == 2)) begin
      for (int i = pre; i < cnt; i++) begin
        mdl[i - pre] = slvpat(msgno, i);
        known[i - pre] = 1'b1;
        cap = 1;
      end
    end
    for (int i = 0; i < BUF; i++) begin
      if (known[i]) begin
        rd(rxa(i), v);
        chk(v[7:0] == mdl[i], rq, $sformatf("rx entry %0d", i), v[7:0], mdl[i]);
      end
    end
    rd(ca(4), v);
    chk(v[1] == !cap, "R13", "receive-empty bit", v[1], !cap);
    msgno = msgno + 1;
  endtask

  initial begin
    logic [15:0] v;
    for (int i = 0; i < BUF; i++) known[i] = 1'b0;
    slv_clr = 1'b1;
    repeat (4) @(negedge clk);
    slv_clr = 1'b0;
    rst_n = 1'b1;

    // R1 reset state
    chk(spi_cs_n == '1, "R1", "cs after reset", spi_cs_n, '1);
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    rd(ca(4), v); chk(v == 16'h0002, "R1", "status after reset", v, 16'h0002);
    rd(ca(2), v); chk(v == 16'h0000, "R1", "int status after reset", v, 0);

    // sweep of types, lengths and devices without prepend (R2 R4 R5 R6)
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c < 4; c++) begin
        int cnt = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 5 : BUF;
        run_msg(t, cnt, msgno % NCS, 0, 0);
      end
    end
    chk((fall_c - rise_c) == HALF, "R3", "clock half period", fall_c - rise_c, HALF);

    // prepend sweep (R7), including prepend longer than the message
    for (int t = 0; t < 3; t++) begin
      run_msg(t, 6, 3, 1, 0);
      run_msg(t, 8, 5, 3, 0);
      run_msg(t, BUF, 7, 15, 0);
      run_msg(t, 2, 1, 4, 0);
    end

    // start while busy (R11)
    run_msg(0, BUF, 2, 0, 1);
    wr(ca(2), 16'h001f);

    // zero-length message (R9)
    wr(ca(0), 16'h0000);
    clr_slave();
    wr(ca(1), 16'h0003);
    wait_idle();
    rd(ca(2), v); chk(v[0] == 1'b1, "R9", "done for empty message", v, 1);
    chk(sbyte == 0, "R9", "clocks for empty message", sbyte, 0);
    wr(ca(2), 16'h001f);

    // oversize length (R12)
    wr(ca(0), 16'(BUF + 1));
    clr_slave();
    wr(ca(1), 16'h0003);
    repeat (60) @(negedge clk);
    rd(ca(2), v); chk(v[2] == 1'b1, "R12", "oversize flag", v, 16'h4);
    rd(ca(4), v); chk(v[2] == 1'b0, "R12", "busy after oversize", v[2], 0);
    chk(sbyte == 0, "R12", "clocks after oversize", sbyte, 0);
    wr(ca(2), 16'h001f);

    // interrupt masking (R10)
    wr(ca(3), 16'h0000);
    wr(ca(0), 16'h4001);
    clr_slave();
    wr(ca(1), 16'h0003);
    wait_idle();
    rd(ca(2), v); chk(v[0] == 1'b1, "R10", "status set while masked", v, 1);
    chk(irq == 1'b0, "R10", "irq while masked", irq, 0);
    wr(ca(3), 16'h0001);
    #1ns chk(irq == 1'b1, "R10", "irq once unmasked", irq, 1);
    wr(ca(2), 16'h0001);
    #1ns chk(irq == 1'b0, "R10", "irq after clear", irq, 0);
    rd(ca(2), v); chk(v == 16'h0000, "R10", "status after clear", v, 0);

    // soft reset mid-message (R13 R14)
    wr(ca(0), 16'(20));
    exp_cs = ~(NCS'(1) << 4);
    clr_slave();
    wr(ca(1), 16'h0043);
    repeat (10) @(negedge clk);
    rd(ca(4), v); chk(v[3:2] == 2'b11, "R13", "busy bits mid-byte", v[3:2], 3);
    chk(spi_cs_n == exp_cs, "R8", "cs mid-message", spi_cs_n, exp_cs);
    wr(ca(1), 16'h0001);
    #1ns chk(spi_cs_n == '1, "R14", "cs after soft reset", spi_cs_n, '1);
    rd(ca(4), v); chk(v[3:2] == 2'b00, "R14", "busy after soft reset", v[3:2], 0);
    repeat (200) @(negedge clk);
    rd(ca(2), v); chk(v[0] == 1'b0, "R14", "no done after abort", v, 0);
    for (int i = 0; i < BUF; i++) known[i] = 1'b0;

    // hard reset returns registers (R14)
    wr(ca(3), 16'h001f);
    wr(ca(5), 16'h003c);
    wr(ca(0), 16'h8005);
    wr(ca(1), 16'h0002);
    rd(ca(3), v); chk(v == 16'h0000, "R14", "mask after hard reset", v, 0);
    rd(ca(5), v); chk(v == 16'h00ff, "R14", "fill after hard reset", v, 16'hff);
    rd(ca(0), v); chk(v == 16'h0000, "R14", "msgctl after hard reset", v, 0);
    rd(ca(2), v); chk(v == 16'h0000, "R14", "int status after hard reset", v, 0);

    // engine still usable afterwards
    run_msg(2, 4, 6, 0, 0);

    summary();
    $finish;
  end
endmodule